// File: doc/BRIEF.md
# Bit-Sliced 32-bit Integer ALU

This block is the combinational arithmetic and logic unit of a simple integer datapath. It is made of identical one-bit cells. Every cell holds an AND path, an OR path and a full-adder sum path. Each cell can invert its A operand, its B operand, or both. All cells share one set of control bits. The carry passes from each cell to the next one above it.

Subtraction, NOR and the signed less-than test have no gates of their own. Inverting B and forcing the carry-in of bit 0 high turns the adder into a subtractor. Inverting both operands and taking the AND path gives NOR. Less-than takes the sign bit of the difference and routes it back into bit 0.

Two flags come with the result. The zero flag supports equality branches. The overflow flag reports signed overflow on the adder path. Immediate extension, shifts, multiply and divide are handled outside this block.

Top module: `alu_bitslice`

## Requirements
- R1: Operation code `0000` drives `res_o = a_i & b_i`.
- R2: Operation code `0001` drives `res_o = a_i | b_i`.
- R3: Operation code `0010` drives `res_o = (a_i + b_i) mod 2^32`.
- R4: Operation code `0110` drives `res_o = (a_i - b_i) mod 2^32`.
- R5: Operation code `1100` drives `res_o = ~(a_i | b_i)`.
- R6: Operation code `0111` drives bits 31..1 of `res_o` to zero.
  - Bit 0 of `res_o` equals bit 31 of the 32-bit truncated difference `a_i - b_i`.
  - This is the raw sign bit, with no correction for overflow.
- R7: `zero_o` is 1 exactly when all 32 bits of `res_o` are 0. This holds for every operation code.
- R8: When `op_i[1:0]` is `10` (add path), `ovf_o` is 1 exactly when the two adder inputs have the same sign and the sum's sign differs from it.
  - The adder inputs are the A and B operands after any inversion.
  - This matches the carry into bit 31 differing from the carry out of bit 31.
- R9: When `op_i[1:0]` is not `10` (AND, OR or less-than paths), `ovf_o` is 0.
- R10: The operation code fields have fixed meanings:
  - Bit 3 inverts A in every cell.
  - Bit 2 inverts B in every cell and sets the bit-0 carry-in to 1.
  - Bits 1..0 pick the cell output: 00 AND, 01 OR, 10 sum, 11 less.
  - Other combinations therefore follow from these rules. For example, `1101` gives `~a_i | ~b_i` and `1110` gives `~a_i + ~b_i + 1`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 32 | Operand A |
| b_i | input | 32 | Operand B |
| op_i | input | 4 | Operation code {invert A, negate B, select[1:0]} |
| res_o | output | 32 | Result |
| zero_o | output | 1 | High when the result is all zeros |
| ovf_o | output | 1 | Signed overflow on the adder path |

## Verification
The bench aims at the operand extremes 0, 1, -1, 0x7FFFFFFF and 0x80000000 in every pairing. These pairings catch the following faults:
- A carry that is cut or misplaced in the chain gives wrong sums near 0xFFFFFFFF.
- An overflow flag taken from the carry out alone would fire on `-1 + 1`.
- An overflow flag taken from the wrong pair of carries would miss `0x7FFFFFFF + 1`.

Less-than runs with the minimum and maximum values so that the raw difference sign wraps. A design that fixed up the sign, or fed the sign back from the wrong cell, gives a different bit 0, or leaves stray upper bits. The bench also runs the unlisted codes `1101` and `1110`. A design that decoded each operation with its own gates, instead of from the shared inversion controls, would get those codes wrong.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int unsigned OP_W = 4;

  typedef enum logic [1:0] {
    SEL_AND  = 2'b00,
    SEL_OR   = 2'b01,
    SEL_SUM  = 2'b10,
    SEL_LESS = 2'b11
  } sel_e;

  typedef struct packed {
    logic a_inv;
    logic b_neg;
    sel_e sel;
  } ctrl_t;
endpackage

// File: rtl/alu_carry_chain.sv
module alu_carry_chain #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         a_inv_i,
  input  logic         b_neg_i,
  output logic [W:0]   carry_o
);
  logic [W-1:0] a_e;
  logic [W-1:0] b_e;
  logic [W:0]   wide_sum;

  assign a_e = a_i ^ {W{a_inv_i}};
  assign b_e = b_i ^ {W{b_neg_i}};

  // Ripple: bit 0 carry-in follows the B negate control.
  always_comb begin
    carry_o[0] = b_neg_i;
    for (int i = 0; i < int'(W); i++) begin
      carry_o[i+1] = (a_e[i] & b_e[i]) | ((a_e[i] | b_e[i]) & carry_o[i]);
    end
  end

  assign wide_sum = {1'b0, a_i} + {1'b0, b_i};

  always_comb begin
    if (!a_inv_i && !b_neg_i) begin
      p_carry_out_r3: assert (carry_o[W] == wide_sum[W])
        else $error("carry out disagrees with wide add");
    end
  end
endmodule

// File: rtl/alu_slice.sv
module alu_slice
  import alu_pkg::*;
(
  input  logic a_i,
  input  logic b_i,
  input  logic a_inv_i,
  input  logic b_neg_i,
  input  sel_e sel_i,
  input  logic carry_i,
  input  logic less_i,
  output logic sum_o,
  output logic res_o
);
  logic a_e;
  logic b_e;

  assign a_e   = a_i ^ a_inv_i;
  assign b_e   = b_i ^ b_neg_i;
  assign sum_o = a_e ^ b_e ^ carry_i;

  always_comb begin
    unique case (sel_i)
      SEL_AND:  res_o = a_e & b_e;
      SEL_OR:   res_o = a_e | b_e;
      SEL_SUM:  res_o = sum_o;
      SEL_LESS: res_o = less_i;
      default:  res_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu_flags.sv
module alu_flags
  import alu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] res_i,
  input  logic         c_into_msb_i,
  input  logic         c_out_msb_i,
  input  sel_e         sel_i,
  output logic         zero_o,
  output logic         ovf_o
);
  assign zero_o = ~(|res_i);
  assign ovf_o  = (sel_i == SEL_SUM) & (c_into_msb_i ^ c_out_msb_i);
endmodule

// File: rtl/alu_bitslice.sv
module alu_bitslice
  import alu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0]    a_i,
  input  logic [W-1:0]    b_i,
  input  logic [OP_W-1:0] op_i,
  output logic [W-1:0]    res_o,
  output logic            zero_o,
  output logic            ovf_o
);
  localparam int unsigned MSB = W - 1;

  ctrl_t        ctrl;
  logic [W:0]   carry_w;
  logic [W-1:0] sum_w;
  logic [W-1:0] res_w;
  logic         set_w;

  assign ctrl = ctrl_t'(op_i);

  alu_carry_chain #(.W(W)) u_chain (
    .a_i     (a_i),
    .b_i     (b_i),
    .a_inv_i (ctrl.a_inv),
    .b_neg_i (ctrl.b_neg),
    .carry_o (carry_w)
  );

  // Sign of the MSB sum feeds back to the less input of bit 0.
  assign set_w = sum_w[MSB];

  for (genvar i = 0; i < int'(W); i++) begin : g_slice
    logic less_w;
    if (i == 0) begin : g_lsb
      assign less_w = set_w;
    end else begin : g_rest
      assign less_w = 1'b0;
    end

    alu_slice u_slice (
      .a_i     (a_i[i]),
      .b_i     (b_i[i]),
      .a_inv_i (ctrl.a_inv),
      .b_neg_i (ctrl.b_neg),
      .sel_i   (ctrl.sel),
      .carry_i (carry_w[i]),
      .less_i  (less_w),
      .sum_o   (sum_w[i]),
      .res_o   (res_w[i])
    );
  end

  alu_flags #(.W(W)) u_flags (
    .res_i        (res_w),
    .c_into_msb_i (carry_w[MSB]),
    .c_out_msb_i  (carry_w[W]),
    .sel_i        (ctrl.sel),
    .zero_o       (zero_o),
    .ovf_o        (ovf_o)
  );

  assign res_o = res_w;

  always_comb begin
    if (op_i == 4'b0010) begin
      p_add_r3: assert (res_o == a_i + b_i) else $error("add mismatch");
      p_add_ovf_r8: assert (ovf_o == ((a_i[MSB] == b_i[MSB]) && (res_o[MSB] != a_i[MSB])))
        else $error("add overflow mismatch");
    end
    if (op_i == 4'b0110) begin
      p_sub_r4: assert (res_o == a_i - b_i) else $error("sub mismatch");
    end
    if (op_i == 4'b1100) begin
      p_nor_r5: assert (res_o == ~(a_i | b_i)) else $error("nor mismatch");
    end
    if (ctrl.sel == SEL_LESS) begin
      p_less_upper_r6: assert ((res_o >> 1) == '0) else $error("less upper bits set");
    end
    if (ctrl.sel != SEL_SUM) begin
      p_no_overflow_r9: assert (!ovf_o) else $error("overflow off adder path");
    end
    p_zero_r7: assert (zero_o == (res_o == '0)) else $error("zero flag mismatch");
  end
endmodule

// File: tb/tb_alu_bitslice.sv
`timescale 1ns/1ps
module tb_alu_bitslice;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] a = '0;
  logic [31:0] b = '0;
  logic [3:0]  op = '0;
  logic [31:0] res;
  logic        zero;
  logic        ovf;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  alu_bitslice dut (
    .a_i    (a),
    .b_i    (b),
    .op_i   (op),
    .res_o  (res),
    .zero_o (zero),
    .ovf_o  (ovf)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s op=%b a=%h b=%h actual=%h expected=%h", tag, op, a, b, act, exp);
    end
  endtask

  function automatic string op_tag(input logic [3:0] o);
    case (o)
      4'b0000: return "R1";
      4'b0001: return "R2";
      4'b0010: return "R3";
      4'b0110: return "R4";
      4'b1100: return "R5";
      4'b0111: return "R6";
      default: return "R10";
    endcase
  endfunction

  // Behavioural model from the requirements.
  task automatic apply(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y);
    logic [31:0] ae, be, sum, er;
    logic        eo;
    @(posedge clk);
    op = o; a = x; b = y;
    ae  = o[3] ? ~x : x;
    be  = o[2] ? ~y : y;
    sum = ae + be + {31'b0, o[2]};
    if (o == 4'b0010) sum = x + y;
    if (o == 4'b0110) sum = x - y;
    case (o[1:0])
      2'b00:   er = ae & be;
      2'b01:   er = ae | be;
      2'b10:   er = sum;
      default: er = {31'b0, sum[31]};
    endcase
    eo = (o[1:0] == 2'b10) && (ae[31] == be[31]) && (sum[31] != ae[31]);
    @(negedge clk);
    check(op_tag(o), res, er);
    check("R7", {31'b0, zero}, {31'b0, (er == 32'h0)});
    check((o[1:0] == 2'b10) ? "R8" : "R9", {31'b0, ovf}, {31'b0, eo});
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] edges [5];
    logic [3:0]  ops [8];
    edges = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h8000_0000};
    ops   = '{4'b0000, 4'b0001, 4'b0010, 4'b0110, 4'b0111, 4'b1100, 4'b1101, 4'b1110};
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", res, 32'h0);
    check("R7", {31'b0, zero}, 32'h1);
    check("R9", {31'b0, ovf}, 32'h0);
    rst_ni = 1'b1;

    // Directed corners
    apply(4'b0010, 32'h7FFF_FFFF, 32'h1);
    check("R8", {31'b0, ovf}, 32'h1);
    apply(4'b0010, 32'hFFFF_FFFF, 32'h1);
    check("R8", {31'b0, ovf}, 32'h0);
    apply(4'b0111, 32'h8000_0000, 32'h1);
    check("R6", res, 32'h0);
    apply(4'b0111, 32'h1, 32'hFFFF_FFFF);
    check("R6", res, 32'h0);
    apply(4'b0110, 32'h5, 32'h5);
    check("R7", {31'b0, zero}, 32'h1);

    for (int k = 0; k < 8; k++)
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++)
          apply(ops[k], edges[i], edges[j]);

    for (int n = 0; n < 300; n++)
      for (int k = 0; k < 8; k++)
        apply(ops[k], $urandom(), $urandom());

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule